// File: doc/BRIEF.md
# Block Memory Copy Engine

This block moves a run of bytes from one region of a byte-wide synchronous memory to another. It keeps three registers in the manner of a classic 8-bit processor's block-move instructions: a source pointer, a destination pointer and a byte count. Software writes all three, plus a flag byte, through a single load strobe while the engine is idle. It then issues a start with two mode bits. One mode bit selects the direction (pointers count up or down). The other selects whether the engine performs one step or repeats until the count is exhausted.

Each step issues a read at the source address and, on the next cycle, writes the returned byte to the destination address. The two pointers then move by one in the chosen direction and the count drops by one. Three flag bits are rewritten after every step and the other flag bits are kept. While a copy runs, `busy` is high, and a one-cycle `done` pulse marks the end. The updated pointers, count and flags stay visible on outputs, so a host can resume or inspect a partial move.

Top module: `blkcopy_engine`

## Requirements
- R1: A step drives `mem_addr` with the source pointer and `mem_we` low for one cycle. On the next cycle it drives `mem_addr` with the destination pointer, `mem_we` high and `mem_wdata` equal to `mem_rdata`, which carries the byte read the cycle before. `mem_we` is never high outside a step's write cycle.
- R2: With `mode_dec` low, the source and destination pointers each increase by 1 after every step, wrapping modulo 2^ADDR_W.
- R3: With `mode_dec` high, the source and destination pointers each decrease by 1 after every step, wrapping modulo 2^ADDR_W.
- R4: The count decreases by 1 after every step, wrapping modulo 2^CNT_W, so a count of 0 becomes all ones.
- R5: After every step, flag bit 2 (parity/overflow) is 1 when the count just produced is nonzero and 0 when it is zero.
- R6: After every step, flag bit 4 (half-carry) and flag bit 1 (subtract) are 0. Every other flag bit keeps the value last loaded.
- R7: With `mode_rep` low a start performs exactly one step. With `mode_rep` high steps repeat until the count reaches zero and stop there. A repeating start with a count of 0 performs 2^CNT_W steps.
- R8: `busy` is high from the cycle after an accepted start for exactly two cycles per step. `done` is then high for exactly one cycle, during which `busy` is low.
- R9: `ld` and `start` are accepted only when the engine is idle (neither `busy` nor `done`). Otherwise they change no register and no step count. `ld` together with `start` in an idle cycle loads first, and the copy uses the new values.
- R10: After reset the pointers, count and flags are zero, and `busy`, `done` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Load strobe for pointers, count and flags |
| ld_src | input | ADDR_W | Source pointer value to load |
| ld_dst | input | ADDR_W | Destination pointer value to load |
| ld_cnt | input | CNT_W | Byte count value to load |
| ld_flags | input | FLAG_W | Flag byte value to load |
| start | input | 1 | Begin a copy |
| mode_dec | input | 1 | 1: pointers count down, 0: up (sampled at start) |
| mode_rep | input | 1 | 1: repeat until count is zero, 0: one step (sampled at start) |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| count | output | CNT_W | Current byte count |
| flags | output | FLAG_W | Current flag byte |

## Verification
The bench builds the engine with ADDR_W and CNT_W both set to 8, over a 256-byte memory model. At that width, pointer wrap in both directions takes a few steps. The zero-count repeat, which runs 2^CNT_W steps, finishes in a few hundred cycles, and so does a copy whose destination overlaps its own source across the whole address space. These cases would be out of reach at 16 bits. With the narrow widths, the memory image after every run can be compared byte by byte with a sequential model.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_FIN  = 2'd3
   } bc_state_e;

   // flag bit positions rewritten by a step
   localparam int FLG_N  = 1;
   localparam int FLG_PV = 2;
   localparam int FLG_H  = 4;

endpackage

// File: rtl/blkcopy_ptr.sv
module blkcopy_ptr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         dec,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] q_next;

   generate
      if (W < 2) begin : g_bad_w
         $error("blkcopy_ptr: W must be at least 2");
      end
   endgenerate

   always_comb begin
      q_next = q;
      if (load)
         q_next = load_val;
      else if (step)
         q_next = dec ? (q - ONE) : (q + ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
   end

   // R2
   ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !dec && !load) |=> (q == $past(q) + ONE));

   // R3
   ptr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dec && !load) |=> (q == $past(q) - ONE));

endmodule

// File: rtl/blkcopy_cnt.sv
module blkcopy_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q,
   output logic         last
);

   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 2) begin : g_bad_w
         $error("blkcopy_cnt: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (step)  q <= q - ONE;
   end

   // this step leaves the count at zero
   assign last = (q == ONE);

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (q == $past(q) - ONE));

endmodule

// File: rtl/blkcopy_fsm.sv
module blkcopy_fsm
   import blkcopy_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      dec_in,
   input  logic      rep_in,
   input  logic      cnt_last,
   output bc_state_e state,
   output logic      step,
   output logic      busy,
   output logic      done,
   output logic      dec_q
);

   bc_state_e state_nx;
   logic      rep_q;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (start) state_nx = ST_RD;
         ST_RD:   state_nx = ST_WR;
         ST_WR:   state_nx = (rep_q && !cnt_last) ? ST_RD : ST_FIN;
         ST_FIN:  state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         dec_q <= 1'b0;
         rep_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && start) begin
            dec_q <= dec_in;
            rep_q <= rep_in;
         end
      end
   end

   assign step = (state == ST_WR);
   assign busy = (state == ST_RD) || (state == ST_WR);
   assign done = (state == ST_FIN);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R1
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD) |=> step);

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
   import blkcopy_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int FLAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_src,
   input  logic [ADDR_W-1:0] ld_dst,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic [FLAG_W-1:0] ld_flags,
   input  logic              start,
   input  logic              mode_dec,
   input  logic              mode_rep,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic [CNT_W-1:0]  count,
   output logic [FLAG_W-1:0] flags
);

   generate
      if (FLAG_W <= FLG_H) begin : g_bad_flag
         $error("blkcopy_engine: FLAG_W too small for the flag positions");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("blkcopy_engine: DATA_W must be positive");
      end
   endgenerate

   bc_state_e         state;
   logic              step;
   logic              dec_q;
   logic              cnt_last;
   logic              ld_ok;
   logic [FLAG_W-1:0] flag_q;
   logic [FLAG_W-1:0] flag_after;

   assign ld_ok = ld && (state == ST_IDLE);

   blkcopy_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dec_in   (mode_dec),
      .rep_in   (mode_rep),
      .cnt_last (cnt_last),
      .state    (state),
      .step     (step),
      .busy     (busy),
      .done     (done),
      .dec_q    (dec_q)
   );

   blkcopy_ptr #(.W(ADDR_W)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ok),
      .load_val (ld_src),
      .step     (step),
      .dec      (dec_q),
      .q        (src_ptr)
   );

   blkcopy_ptr #(.W(ADDR_W)) u_dst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ok),
      .load_val (ld_dst),
      .step     (step),
      .dec      (dec_q),
      .q        (dst_ptr)
   );

   blkcopy_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ok),
      .load_val (ld_cnt),
      .step     (step),
      .q        (count),
      .last     (cnt_last)
   );

   // per-bit flag update after a step
   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         if (i == FLG_PV) begin : g_pv
            assign flag_after[i] = !cnt_last;
         end else if (i == FLG_H || i == FLG_N) begin : g_clr
            assign flag_after[i] = 1'b0;
         end else begin : g_keep
            assign flag_after[i] = flag_q[i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= '0;
      else if (ld_ok) flag_q <= ld_flags;
      else if (step)  flag_q <= flag_after;
   end

   assign flags     = flag_q;
   assign mem_addr  = step ? dst_ptr : src_ptr;
   assign mem_we    = step;
   assign mem_wdata = mem_rdata;

   // R6
   hn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (!flag_q[FLG_H] && !flag_q[FLG_N]));

   // R5
   pv_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (flag_q[FLG_PV] == (count != '0)));

   // R1
   we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && !step) |=> ($stable(src_ptr) && $stable(dst_ptr)
                                       && $stable(count) && $stable(flag_q)));

endmodule

// File: tb/blkcopy_engine_test.sv
module blkcopy_engine_test;

   localparam int AW = 8;
   localparam int CW = 8;
   localparam int MSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld = 1'b0;
   logic [AW-1:0] ld_src = '0;
   logic [AW-1:0] ld_dst = '0;
   logic [CW-1:0] ld_cnt = '0;
   logic [7:0]    ld_flags = '0;
   logic          start = 1'b0;
   logic          mode_dec = 1'b0;
   logic          mode_rep = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;
   logic          busy, done;
   logic [AW-1:0] src_ptr, dst_ptr;
   logic [CW-1:0] count;
   logic [7:0]    flags;

   logic [7:0] mem [MSZ];
   logic [7:0] refm [MSZ];

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   blkcopy_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(8), .FLAG_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_src(ld_src), .ld_dst(ld_dst),
      .ld_cnt(ld_cnt), .ld_flags(ld_flags), .start(start),
      .mode_dec(mode_dec), .mode_rep(mode_rep), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
      .count(count), .flags(flags)
   );

   // memory model: one cycle read latency
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   // vector table: src, dst, cnt, dec, rep, flags
   localparam int NV = 7;
   localparam logic [7:0] V_SRC [NV] = '{8'h0A, 8'h28, 8'h05, 8'h64, 8'hFE, 8'h01, 8'h70};
   localparam logic [7:0] V_DST [NV] = '{8'h50, 8'h14, 8'h32, 8'h65, 8'h30, 8'hC0, 8'h90};
   localparam logic [7:0] V_CNT [NV] = '{8'd5,  8'd4,  8'd9,  8'd6,  8'd4,  8'd3,  8'd1};
   localparam bit         V_DEC [NV] = '{1'b0,  1'b1,  1'b0,  1'b0,  1'b0,  1'b1,  1'b0};
   localparam bit         V_REP [NV] = '{1'b1,  1'b1,  1'b0,  1'b1,  1'b1,  1'b1,  1'b0};
   localparam logic [7:0] V_FLG [NV] = '{8'hFF, 8'h00, 8'hA5, 8'h16, 8'h5A, 8'hC3, 8'hFF};

   task automatic run_copy(input logic [7:0] s, input logic [7:0] d, input logic [7:0] c,
                           input bit dec, input bit rep, input logic [7:0] f,
                           input bit disturb);
      int n, ps, pd, busy_cnt, guard;
      logic [7:0] e_flg;
      int e_cnt;
      bit mem_ok;
      for (int i = 0; i < MSZ; i++) begin
         mem[i]  = 8'((i * 37 + c * 11 + s) & 8'hFF);
         refm[i] = mem[i];
      end
      n  = rep ? ((c == 0) ? MSZ : int'(c)) : 1;
      ps = s;
      pd = d;
      for (int k = 0; k < n; k++) begin
         refm[pd] = refm[ps];
         ps = dec ? ((ps + MSZ - 1) % MSZ) : ((ps + 1) % MSZ);
         pd = dec ? ((pd + MSZ - 1) % MSZ) : ((pd + 1) % MSZ);
      end
      e_cnt = (int'(c) + 256 - n) % 256;
      e_flg = (f & 8'hE9) | ((e_cnt != 0) ? 8'h04 : 8'h00);

      ld = 1'b1; ld_src = s; ld_dst = d; ld_cnt = c; ld_flags = f;
      mode_dec = dec; mode_rep = rep; start = 1'b1;
      @(negedge clk);
      ld = 1'b0; start = 1'b0;
      busy_cnt = 0;
      guard = 0;
      while (!done && guard < 2000) begin
         if (busy) busy_cnt++;
         if (disturb && busy_cnt == 3) begin
            ld = 1'b1; ld_src = 8'h55; ld_dst = 8'hAA; ld_cnt = 8'h77;
            ld_flags = 8'h00; start = 1'b1;
         end else begin
            ld = 1'b0; start = 1'b0;
         end
         @(negedge clk);
         guard++;
      end
      ld = 1'b0; start = 1'b0;
      chk(done && !busy, "R8 done with busy low", {busy, done}, 1);
      chk(busy_cnt == 2 * n, rep ? "R7 repeat busy cycles" : "R7 single busy cycles",
          busy_cnt, 2 * n);
      chk(src_ptr == 8'(ps), dec ? "R3 src" : "R2 src", src_ptr, ps);
      chk(dst_ptr == 8'(pd), dec ? "R3 dst" : "R2 dst", dst_ptr, pd);
      chk(count == 8'(e_cnt), "R4 count", count, e_cnt);
      chk(flags[2] == (e_cnt != 0), "R5 pv", flags[2], (e_cnt != 0));
      chk(flags == e_flg, "R6 flags", flags, e_flg);
      @(negedge clk);
      chk(!done && !busy, "R8 done one cycle", {busy, done}, 0);
      mem_ok = 1'b1;
      for (int i = 0; i < MSZ; i++)
         if (mem[i] !== refm[i]) mem_ok = 1'b0;
      chk(mem_ok, "R1 memory image", mem_ok, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(src_ptr == 0 && dst_ptr == 0, "R10 pointers", {src_ptr, dst_ptr}, 0);
      chk(count == 0 && flags == 0, "R10 count flags", {count, flags}, 0);
      chk(!busy && !done && !mem_we, "R10 controls", {busy, done, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++)
         run_copy(V_SRC[v], V_DST[v], V_CNT[v], V_DEC[v], V_REP[v], V_FLG[v], 1'b0);

      // R7 zero count in repeat mode: full 2^CW steps over overlapping range
      run_copy(8'h00, 8'h80, 8'h00, 1'b0, 1'b1, 8'h12, 1'b0);
      // R4 zero count single step wraps to all ones
      run_copy(8'h20, 8'h40, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
      // R9 load and start pulsed mid-copy are ignored
      run_copy(8'h10, 8'hB0, 8'd6, 1'b0, 1'b1, 8'h81, 1'b1);
      run_copy(8'hF0, 8'h08, 8'd5, 1'b1, 1'b1, 8'h3C, 1'b1);

      // R9 load alone while idle changes registers without a copy
      ld = 1'b1; ld_src = 8'h33; ld_dst = 8'h44; ld_cnt = 8'h22; ld_flags = 8'h96;
      @(negedge clk);
      ld = 1'b0;
      @(negedge clk);
      chk(src_ptr == 8'h33 && dst_ptr == 8'h44 && count == 8'h22 && flags == 8'h96,
          "R9 idle load", {src_ptr, dst_ptr, count, flags}, 32'h33442296);
      chk(!busy && !mem_we, "R9 idle load no copy", {busy, mem_we}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule